// File: doc/BRIEF.md
# Configurable Serial Bit-Shift Engine

This block moves one word of a run-time selectable length, from 1 up to 32 bits, over a three-wire serial link made of a data output, a data input and a serial clock. The idle clock level, which edge launches and which edge captures, and the bit order are all chosen per transfer. The parallel word to send, the settings and a one-cycle start pulse are presented together. The engine then shifts the word out while it shifts the peer's word in, and raises a one-cycle done pulse when the received word is ready on the parallel output.

In generating mode the engine derives the serial clock from the system clock. It makes one serial edge every half of a programmed period, counted in system cycles. In following mode it takes every transition of an external clock pin as an edge, after a synchronizer, and holds its own clock output at the idle level. Internally the engine counts both rising and falling serial edges. The low bit of that count, together with the phase and polarity settings, decides the clock level and whether an edge captures or launches data. A stop pulse aborts a transfer at any point.

Top module: `serial_shift_engine`

## Requirements
- R1: A start while idle is refused when `cfg_width` is 0 or above 32, or when `cfg_period` is below 2. A refused start leaves `busy` low and sets `cfg_err`. `cfg_err` stays high until the next accepted start clears it.
- R2: `busy` rises in the cycle after an accepted start and falls with `done` or after `stop`. A start while busy has no effect on the running transfer, on its length, on its data or on `cfg_err`.
- R3: When `cfg_master` is 1, a serial edge occurs every `cfg_period/2` system cycles, rounded down. `done` is seen exactly 2·width·(`cfg_period/2`) cycles after the cycle in which start was sampled.
- R4: At an accepted start `sclk_out` takes the level `cfg_cpol`. When `cfg_master` is 1, it toggles on each of the 2·width serial edges and so ends at `cfg_cpol`. When `cfg_master` is 0, it stays at `cfg_cpol` for the whole transfer.
- R5: Serial edges are numbered from 0. When `cfg_cpha` is 0, the first data bit is on `sdo` in the cycle after start, even edges capture `sdi` and odd edges launch the next bit. When `cfg_cpha` is 1, even edges launch and odd edges capture.
- R6: When `cfg_lsb_first` is 0, bit width-1 of `tx_word` is sent first. The first bit received ends up at bit width-1 of `rx_word`.
- R7: When `cfg_lsb_first` is 1, bit 0 of `tx_word` is sent first. The first bit received ends up at bit 0 of `rx_word`.
- R8: `rx_word` updates together with a one-cycle `done` pulse after the 2·width-th edge. Bits at and above width are zero.
- R9: When `cfg_master` is 0, every transition of `sclk_in`, rising or falling, is one serial edge and passes through a two-flop synchronizer. Transitions while idle are ignored.
- R10: `stop` during a transfer clears `busy` without a `done` pulse, leaves `rx_word` unchanged and returns `sclk_out` to the transfer's `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 6 | Word length in bits, valid 1..32 |
| cfg_period | input | 16 | Serial clock period in system cycles for generating mode, at least 2 |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: capture on even edges; 1: capture on odd edges |
| cfg_lsb_first | input | 1 | 0: most significant bit first; 1: least significant bit first |
| cfg_master | input | 1 | 1: generate the serial clock; 0: follow `sclk_in` |
| tx_word | input | 32 | Word to send, taken at an accepted start |
| start | input | 1 | Start pulse |
| stop | input | 1 | Abort pulse |
| sdi | input | 1 | Serial data in |
| sclk_in | input | 1 | External serial clock for following mode |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated serial clock |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last idle start was refused |
| rx_word | output | 32 | Received word |

## Verification
The embedded properties assume that the settings and `tx_word` are only meaningful when start is sampled while idle. They also assume that an accepted generating transfer has a half period of at least one cycle, which the start check guarantees. In following mode, `sdi` must stay steady for several system cycles around each `sclk_in` transition, and transitions must be spaced well beyond the synchronizer latency. The bench drives `sclk_in` with six idle cycles after each transition and two before it. It changes `sdi` only just before a capture transition. In generating mode it updates `sdi` on the falling system edge after each capture, which is always before the next capture.

// File: rtl/sse_pkg.sv
`timescale 1ns/1ps
package sse_pkg;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;

   // Edge role from the low bit of the edge counter and the phase setting:
   // 1 means the edge captures input data, 0 means it launches output data.
   function automatic logic edge_is_sample(input logic cnt_lsb, input logic cpha);
      return ~(cnt_lsb ^ cpha);
   endfunction

endpackage

// File: rtl/sse_edge_src.sv
`timescale 1ns/1ps
module sse_edge_src #(
   parameter int unsigned PER_W = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             master,
   input  logic [PER_W-1:0] half,
   input  logic             sclk_in,
   output logic             edge_p
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sse_edge_src: SYNC_STAGES must be at least 2");
   end

   // ---------------- generating mode: half-period timer -------------
   logic [PER_W-1:0] tcnt;
   logic             tick;

   assign tick = run & master & (tcnt == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  tcnt <= '0;
      else if (!(run && master))   tcnt <= '0;
      else if (tick)               tcnt <= '0;
      else                         tcnt <= tcnt + 1'b1;
   end

   assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && master) |-> (tcnt < half));

   // ---------------- following mode: synchronizer + both-edge detect -
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   ext_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_edge = run & ~master & (sync_q[SYNC_STAGES-1] ^ prev_q);
   assign edge_p   = tick | ext_edge;

endmodule

// File: rtl/sse_shift_core.sv
`timescale 1ns/1ps
module sse_shift_core
   import sse_pkg::*;
#(
   parameter int unsigned MAX_W = 32,
   parameter int unsigned WW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAX_W-1:0] load_word,
   input  logic [WW-1:0]    load_width,
   input  logic             load_lsb,
   input  logic             load_cpha,
   input  logic             step,
   input  logic             is_sample,
   input  logic             sdi,
   output logic             sdo,
   output logic [MAX_W-1:0] word_nx
);

   function automatic logic [MAX_W-1:0] low_mask(input logic [WW-1:0] w);
      return {MAX_W{1'b1}} >> (MAX_W - w);
   endfunction

   logic [MAX_W-1:0] data_q, mask_q, data_d, sampled, top_sh, load_top_sh;
   logic [WW-1:0]    width_q;
   bit_order_e       order_q;
   logic             launch_bit, load_first;

   // Bit at position width-1, taken by shifting instead of a variable index.
   assign top_sh      = data_q >> (width_q - 1'b1);
   assign load_top_sh = load_word >> (load_width - 1'b1);

   assign launch_bit = (order_q == ORDER_LSB_FIRST) ? data_q[0] : top_sh[0];
   assign load_first = load_lsb ? load_word[0] : load_top_sh[0];

   always_comb begin
      if (order_q == ORDER_LSB_FIRST)
         sampled = (data_q >> 1) | (MAX_W'(sdi) << (width_q - 1'b1));
      else
         sampled = (data_q << 1) | MAX_W'(sdi);
      sampled = sampled & mask_q;
   end

   always_comb begin
      data_d = data_q;
      if (load)                   data_d = load_word & low_mask(load_width);
      else if (step && is_sample) data_d = sampled;
   end

   assign word_nx = data_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         mask_q  <= '0;
         width_q <= WW'(1);
         order_q <= ORDER_MSB_FIRST;
         sdo     <= 1'b0;
      end else begin
         data_q <= data_d;
         if (load) begin
            width_q <= load_width;
            mask_q  <= low_mask(load_width);
            order_q <= bit_order_e'(load_lsb);
            if (!load_cpha) sdo <= load_first;
         end else if (step && !is_sample) begin
            sdo <= launch_bit;
         end
      end
   end

   assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_q & ~mask_q) == '0);

endmodule

// File: rtl/serial_shift_engine.sv
`timescale 1ns/1ps
module serial_shift_engine
   import sse_pkg::*;
#(
   parameter  int unsigned MAX_W       = 32,
   parameter  int unsigned PER_W       = 16,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned WW          = $clog2(MAX_W + 1),
   localparam int unsigned ECW         = $clog2(2 * MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WW-1:0]    cfg_width,
   input  logic [PER_W-1:0] cfg_period,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic             cfg_lsb_first,
   input  logic             cfg_master,
   input  logic [MAX_W-1:0] tx_word,
   input  logic             start,
   input  logic             stop,
   input  logic             sdi,
   input  logic             sclk_in,
   output logic             sdo,
   output logic             sclk_out,
   output logic             busy,
   output logic             done,
   output logic             cfg_err,
   output logic [MAX_W-1:0] rx_word
);

   if (MAX_W < 1) begin : g_bad_width
      $error("serial_shift_engine: MAX_W must be at least 1");
   end
   if (PER_W < 2) begin : g_bad_period
      $error("serial_shift_engine: PER_W must be at least 2");
   end

   logic             busy_q, done_q, err_q, sclk_q;
   logic             cpol_q, cpha_q, master_q;
   logic [WW-1:0]    width_q;
   logic [PER_W-1:0] half_q;
   logic [ECW-1:0]   edge_cnt, lim;
   logic [MAX_W-1:0] rx_q, word_nx;
   logic             cfg_ok, accept, edge_p, step, sample_now, last_edge;

   assign cfg_ok     = (cfg_width != '0) && (cfg_width <= WW'(MAX_W))
                       && (cfg_period >= PER_W'(2));
   assign accept     = start & ~busy_q & cfg_ok;
   assign step       = busy_q & edge_p & ~stop;
   assign sample_now = edge_is_sample(edge_cnt[0], cpha_q);
   assign lim        = ECW'({width_q, 1'b0});
   assign last_edge  = step && ((edge_cnt + 1'b1) == lim);

   sse_edge_src #(
      .PER_W       (PER_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_edge_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy_q),
      .master  (master_q),
      .half    (half_q),
      .sclk_in (sclk_in),
      .edge_p  (edge_p)
   );

   sse_shift_core #(
      .MAX_W (MAX_W),
      .WW    (WW)
   ) i_shift_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .load_word  (tx_word),
      .load_width (cfg_width),
      .load_lsb   (cfg_lsb_first),
      .load_cpha  (cfg_cpha),
      .step       (step),
      .is_sample  (sample_now),
      .sdi        (sdi),
      .sdo        (sdo),
      .word_nx    (word_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         sclk_q   <= 1'b0;
         cpol_q   <= 1'b0;
         cpha_q   <= 1'b0;
         master_q <= 1'b0;
         width_q  <= WW'(1);
         half_q   <= PER_W'(1);
         edge_cnt <= '0;
         rx_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q   <= 1'b1;
            err_q    <= 1'b0;
            edge_cnt <= '0;
            width_q  <= cfg_width;
            half_q   <= cfg_period >> 1;
            cpol_q   <= cfg_cpol;
            cpha_q   <= cfg_cpha;
            master_q <= cfg_master;
            sclk_q   <= cfg_cpol;
         end else if (start && !busy_q) begin
            err_q <= 1'b1;
         end

         if (busy_q && stop) begin
            busy_q <= 1'b0;
            sclk_q <= cpol_q;
         end else if (step) begin
            edge_cnt <= edge_cnt + 1'b1;
            if (master_q) sclk_q <= ~sclk_q;
            if (last_edge) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               rx_q   <= word_nx;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign cfg_err  = err_q;
   assign sclk_out = sclk_q;
   assign rx_word  = rx_q;

   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_ignore_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(width_q) && $stable(cpha_q) && $stable(master_q)));

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (edge_cnt < lim));

   assert_follow_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !master_q) |-> (sclk_out == cpol_q));

   assert_gen_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && master_q && edge_p && !stop) |=> (sclk_out != $past(sclk_out)));

endmodule

// File: tb/test_serial_shift_engine.sv
`timescale 1ns/1ps
module test_serial_shift_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_width = 6'd8;
   logic [15:0] cfg_period = 16'd4;
   logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_master = 1'b1;
   logic [31:0] tx_word = '0;
   logic        start = 1'b0, stop = 1'b0, sdi = 1'b0, sclk_in = 1'b0;
   logic        sdo, sclk_out, busy, done, cfg_err;
   logic [31:0] rx_word;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // follow-mode bookkeeping
   int done_seen;
   bit done_early;
   bit clk_moved;
   bit toggles_over;
   bit want_cpol;

   always #2.5 clk = ~clk;

   serial_shift_engine i_serial_shift_engine (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_period(cfg_period),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
      .cfg_master(cfg_master), .tx_word(tx_word), .start(start), .stop(stop),
      .sdi(sdi), .sclk_in(sclk_in), .sdo(sdo), .sclk_out(sclk_out), .busy(busy),
      .done(done), .cfg_err(cfg_err), .rx_word(rx_word)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit [31:0] wmask(input int w);
      return 32'hFFFF_FFFF >> (32 - w);
   endfunction

   function automatic bit pbit(input bit [31:0] word, input int w, input bit lsb, input int j);
      return lsb ? word[j] : word[w-1-j];
   endfunction

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run_master(input int w, input bit cpol, input bit cpha, input bit lsb,
                             input int period, input bit [31:0] tx, input bit [31:0] peer,
                             input bit poke);
      bit        prev;
      int        e, j, cnt;
      bit        dn;
      bit [31:0] got;
      @(negedge clk);
      cfg_width = 6'(w); cfg_period = 16'(period); cfg_cpol = cpol; cfg_cpha = cpha;
      cfg_lsb_first = lsb; cfg_master = 1'b1; tx_word = tx;
      sdi = pbit(peer, w, lsb, 0);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy == 1'b1, "R2 busy after accepted start", busy, 1);
      check(sclk_out == cpol, "R4 level at start", sclk_out, cpol);
      if (!cpha) check(sdo == pbit(tx, w, lsb, 0), "R5 first bit before edges", sdo, pbit(tx, w, lsb, 0));
      prev = sclk_out; e = 0; j = 0; cnt = 0; dn = 0; got = '0;
      while (!dn && cnt < 5000) begin
         @(negedge clk); cnt++;
         if (poke && cnt == 3) begin start = 1'b1; tx_word = ~tx; cfg_width = 6'd3; end
         if (poke && cnt == 4) start = 1'b0;
         if (sclk_out != prev) begin
            if (((e & 1) ^ int'(cpha)) == 0) begin
               if (lsb) got[j] = sdo; else got[w-1-j] = sdo;
               j++;
               if (j < w) sdi = pbit(peer, w, lsb, j);
            end
            e++;
            prev = sclk_out;
         end
         if (done) dn = 1;
      end
      check(cnt == 2 * w * (period / 2), "R3 cycles from start to done", cnt, 2 * w * (period / 2));
      check(e == 2 * w, "R4 clock transitions per transfer", e, 2 * w);
      check(got == (tx & wmask(w)), lsb ? "R7 sent word (R5 launch edges)" : "R6 sent word (R5 launch edges)",
            got, tx & wmask(w));
      check(rx_word == (peer & wmask(w)), lsb ? "R7 received word (R8)" : "R6 received word (R8)",
            rx_word, peer & wmask(w));
      check(busy == 1'b0, "R2 busy low with done", busy, 0);
      check(sclk_out == cpol, "R4 clock back at idle level", sclk_out, cpol);
      check(cfg_err == 1'b0, "R1 error clear after accepted start", cfg_err, 0);
      @(negedge clk);
      check(done == 1'b0, "R8 done is one cycle", done, 0);
   endtask

   task automatic wait_follow(input int n);
      repeat (n) begin
         @(negedge clk);
         if (done) begin
            done_seen++;
            if (!toggles_over) done_early = 1;
         end
         if (busy && sclk_out != want_cpol) clk_moved = 1;
      end
   endtask

   task automatic run_slave(input int w, input bit cpol, input bit cpha, input bit lsb,
                            input bit [31:0] tx, input bit [31:0] peer);
      int        j;
      bit [31:0] got;
      @(negedge clk);
      cfg_width = 6'(w); cfg_period = 16'd4; cfg_cpol = cpol; cfg_cpha = cpha;
      cfg_lsb_first = lsb; cfg_master = 1'b0; tx_word = tx;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(sclk_out == cpol, "R4 level at start (follow)", sclk_out, cpol);
      done_seen = 0; done_early = 0; clk_moved = 0; toggles_over = 0; want_cpol = cpol;
      j = 0; got = '0;
      for (int e = 0; e < 2 * w; e++) begin
         if (((e & 1) ^ int'(cpha)) == 0) begin
            if (lsb) got[j] = sdo; else got[w-1-j] = sdo;
            sdi = pbit(peer, w, lsb, j);
            j++;
         end
         wait_follow(2);
         sclk_in = ~sclk_in;
         if (e == 2 * w - 1) toggles_over = 1;
         wait_follow(6);
      end
      wait_follow(6);
      check(done_seen == 1, "R9 one done after 2*width transitions", done_seen, 1);
      check(done_early == 1'b0, "R9 no done before last transition", done_early, 0);
      check(clk_moved == 1'b0, "R4 clock held in follow mode", clk_moved, 0);
      check(got == (tx & wmask(w)), lsb ? "R7 sent word follow (R5)" : "R6 sent word follow (R5)",
            got, tx & wmask(w));
      check(rx_word == (peer & wmask(w)), lsb ? "R7 received word follow (R8)" : "R6 received word follow (R8)",
            rx_word, peer & wmask(w));
      check(busy == 1'b0, "R2 busy low after follow transfer", busy, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      bit [31:0] rx0;
      bit        lvl0;
      int        dcnt;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check(busy == 0, "R2 reset busy", busy, 0);
      check(done == 0, "R8 reset done", done, 0);
      check(cfg_err == 0, "R1 reset error flag", cfg_err, 0);
      check(rx_word == 0, "R8 reset receive word", rx_word, 0);
      check(sclk_out == 0, "R4 reset clock level", sclk_out, 0);

      // R1: refused settings
      cfg_master = 1'b1; cfg_period = 16'd4; cfg_width = 6'd0;
      pulse_start();
      check(cfg_err == 1, "R1 width 0 refused", cfg_err, 1);
      check(busy == 0, "R1 width 0 no transfer", busy, 0);
      cfg_width = 6'd33;
      pulse_start();
      check(cfg_err == 1, "R1 width 33 refused", cfg_err, 1);
      check(busy == 0, "R1 width 33 no transfer", busy, 0);
      cfg_width = 6'd8; cfg_period = 16'd1;
      pulse_start();
      check(cfg_err == 1, "R1 period 1 refused", cfg_err, 1);
      check(busy == 0, "R1 period 1 no transfer", busy, 0);

      // corner widths and orders
      run_master(1, 0, 0, 0, 2, 32'h1, 32'h0, 0);
      run_master(1, 1, 1, 1, 3, 32'h0, 32'h1, 0);
      run_master(32, 0, 0, 0, 4, 32'hA5C3_0F81, 32'h1234_5678, 0);
      run_master(32, 1, 1, 1, 2, 32'h8000_0001, 32'hDEAD_BEEF, 0);
      run_slave(32, 0, 0, 1, 32'hC0FF_EE11, 32'h7654_3210);
      run_slave(1, 1, 1, 0, 32'h1, 32'h1);

      // R2: start while busy ignored
      run_master(8, 0, 1, 0, 4, 32'h0000_00B6, 32'h0000_0059, 1);

      // R10: stop mid-transfer
      rx0 = rx_word;
      @(negedge clk);
      cfg_width = 6'd16; cfg_period = 16'd6; cfg_cpol = 1'b1; cfg_cpha = 1'b0;
      cfg_master = 1'b1; tx_word = 32'h0000_F00D;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      check(busy == 0, "R10 stop clears busy", busy, 0);
      check(sclk_out == 1'b1, "R10 clock back to idle level", sclk_out, 1);
      dcnt = 0;
      repeat (80) begin @(negedge clk); if (done) dcnt++; end
      check(dcnt == 0, "R10 no done after stop", dcnt, 0);
      check(rx_word == rx0, "R10 receive word kept", rx_word, rx0);

      // R9: idle transitions on sclk_in ignored
      cfg_master = 1'b0;
      lvl0 = sclk_out;
      dcnt = 0;
      for (int k = 0; k < 6; k++) begin
         sclk_in = ~sclk_in;
         repeat (5) begin @(negedge clk); if (done || busy) dcnt++; end
      end
      check(dcnt == 0, "R9 idle transitions start nothing", dcnt, 0);
      check(rx_word == rx0, "R9 idle transitions keep receive word", rx_word, rx0);
      check(sclk_out == lvl0, "R9 idle transitions keep clock output", sclk_out, lvl0);
      run_slave(5, 1, 0, 0, 32'h15, 32'h0A);

      // constrained random mix
      for (int n = 0; n < 50; n++) begin
         int        w;
         bit        cp, ph, lf;
         bit [31:0] a, b;
         w  = $urandom_range(1, 32);
         cp = 1'($urandom_range(0, 1));
         ph = 1'($urandom_range(0, 1));
         lf = 1'($urandom_range(0, 1));
         a  = $urandom;
         b  = $urandom;
         if ($urandom_range(0, 2) != 0)
            run_master(w, cp, ph, lf, $urandom_range(2, 9), a, b, 0);
         else
            run_slave(w, cp, ph, lf, a, b);
      end

      summary();
   end

endmodule